// File: doc/BRIEF.md
# Debug Halt Suspend Combiner

This block turns the debug-halt indications of two processors into one suspend line per peripheral. Either processor can be halted by a debugger at any time. A peripheral that should freeze while software is stopped watches its suspend line. Each peripheral has a 3-bit select field. The field chooses whether its suspend line follows processor A alone, processor B alone, both processors together (AND), either processor (OR), or neither.

The two halt inputs arrive from foreign clock domains. Each passes through a two-flop synchronizer clocked by the control interface clock. The combined result is then registered. A halt edge therefore reaches the suspend outputs after a fixed three cycles. The select fields are written one at a time through a plain indexed write port. A peripheral built without suspend support is marked by a cleared bit in a build-time mask, and its output stays low for good.

Top module: `dbg_suspend_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every suspend output is 0 and every select field holds the off code 0.
- R2: Select code 1 makes the module's suspend equal processor A's halt. A change on the halt input shows at the output three rising edges after it is first sampled.
- R3: Select code 2 makes the module's suspend equal processor B's halt, with the same three-edge latency.
- R4: Select code 3 raises the suspend only while both processors are halted.
- R5: Select code 4 raises the suspend while at least one processor is halted. While A stays halted, toggling B leaves that output at 1.
- R6: Select codes 0, 5, 6 and 7 force the module's suspend to 0.
- R7: A module whose bit in the parameter USE_MASK is 0 always drives 0, whatever its select field holds.
- R8: A write with `cfg_we_i` high stores `cfg_sel_i` into field `cfg_idx_i` on that rising edge, and the output reflects it after the next edge. A write to an index of NUM_MOD or above changes nothing.
- R9: If neither halt input was high when sampled three edges earlier, every suspend output is 0.
- R10: While both halt inputs hold steady and no field is written, the suspend outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_a_i | input | 1 | Processor A debug halt, asynchronous |
| halt_b_i | input | 1 | Processor B debug halt, asynchronous |
| cfg_we_i | input | 1 | Select field write strobe |
| cfg_idx_i | input | IDX_W | Index of the field to write |
| cfg_sel_i | input | 3 | Select code to store |
| susp_o | output | NUM_MOD | Per-module suspend outputs |

## Verification
A select-field write and a halt edge can reach the output register on the same clock edge. The bench provokes this by writing a field, such as switching a module to OR, while a halt input that was raised earlier is still crossing the synchronizer. Its scoreboard expects the old select combined with the old halt until the write's one-cycle path lands. From then on it expects the new select with the synchronized halt, so an off-by-one on either path shows up as a mismatch. The OR case is also judged during stepping: B is toggled under a held A, and the OR output must stay high in every cycle.

// File: rtl/dbgsusp_pkg.sv
package dbgsusp_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF = 3'd0,
    SEL_A   = 3'd1,
    SEL_B   = 3'd2,
    SEL_AND = 3'd3,
    SEL_OR  = 3'd4
  } susp_sel_e;

  // Map a select code and the two synchronized halts to one suspend bit.
  function automatic logic susp_combine(input logic [SEL_W-1:0] sel,
                                        input logic a, input logic b);
    logic r;
    case (sel)
      SEL_A:   r = a;
      SEL_B:   r = b;
      SEL_AND: r = a & b;
      SEL_OR:  r = a | b;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbgsusp_sync.sv
module dbgsusp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbgsusp_cfg.sv
module dbgsusp_cfg
  import dbgsusp_pkg::*;
#(
  parameter int NUM_MOD = 6,
  parameter int IDX_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [NUM_MOD-1:0][SEL_W-1:0] sel_o
);

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_field
      logic hit;
      assign hit = we_i && (idx_i == IDX_W'(m));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sel_o[m] <= SEL_OFF;
        else if (hit) sel_o[m] <= sel_i;
      end
    end
  endgenerate

endmodule

// File: rtl/dbgsusp_lane.sv
module dbgsusp_lane
  import dbgsusp_pkg::*;
#(
  parameter bit USED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             halt_a_i,
  input  logic             halt_b_i,
  output logic             susp_o
);

  generate
    if (USED) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) susp_o <= 1'b0;
        else        susp_o <= susp_combine(sel_i, halt_a_i, halt_b_i);
      end
    end else begin : g_tied
      logic unused_in;
      assign unused_in = ^{sel_i, halt_a_i, halt_b_i, clk, rst_n};
      assign susp_o    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dbg_suspend_combiner.sv
module dbg_suspend_combiner
  import dbgsusp_pkg::*;
#(
  parameter int               NUM_MOD  = 6,
  parameter logic [NUM_MOD-1:0] USE_MASK = 6'b101111,
  parameter int               SYNC_STG = 2,
  localparam int              IDX_W    = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_a_i,
  input  logic               halt_b_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  output logic [NUM_MOD-1:0] susp_o
);

  logic a_sync, b_sync;
  logic [NUM_MOD-1:0][SEL_W-1:0] sel_q;

  dbgsusp_sync #(.STAGES(SYNC_STG)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .d_i(halt_a_i), .q_o(a_sync));

  dbgsusp_sync #(.STAGES(SYNC_STG)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .d_i(halt_b_i), .q_o(b_sync));

  dbgsusp_cfg #(.NUM_MOD(NUM_MOD), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
    .sel_i(cfg_sel_i), .sel_o(sel_q));

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_lane
      dbgsusp_lane #(.USED(USE_MASK[m])) u_lane (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_q[m]),
        .halt_a_i(a_sync), .halt_b_i(b_sync), .susp_o(susp_o[m]));
    end
  endgenerate

endmodule

// File: rtl/dbg_suspend_combiner_chk.sv
module dbg_suspend_combiner_chk #(
  parameter int               NUM_MOD  = 6,
  parameter logic [NUM_MOD-1:0] USE_MASK = 6'b101111
) (
  input logic               clk,
  input logic               rst_n,
  input logic               halt_a_i,
  input logic               halt_b_i,
  input logic               cfg_we_i,
  input logic [NUM_MOD-1:0] susp_o
);

  logic [2:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  // R1: outputs clear in the cycle after reset.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (susp_o == '0));

  // R7: modules without suspend support never raise their line.
  assert_unused_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_o & ~USE_MASK) == '0);

  // R9: no halt seen three edges back means every line is low.
  assert_quiet_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd4 && !$past(halt_a_i, 3) && !$past(halt_b_i, 3))
      |-> (susp_o == '0));

  // R10: steady halts and no field write keep the outputs unchanged.
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd6 &&
     $past(halt_a_i, 3) == $past(halt_a_i, 4) &&
     $past(halt_b_i, 3) == $past(halt_b_i, 4) &&
     !$past(cfg_we_i, 2)) |-> $stable(susp_o));

endmodule

bind dbg_suspend_combiner dbg_suspend_combiner_chk #(
  .NUM_MOD(NUM_MOD), .USE_MASK(USE_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_a_i(halt_a_i), .halt_b_i(halt_b_i),
  .cfg_we_i(cfg_we_i), .susp_o(susp_o));

// File: tb/sim_dbg_suspend_combiner.sv
module sim_dbg_suspend_combiner;

  localparam int NM = 6;
  localparam logic [NM-1:0] MASK = 6'b101111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ha = 1'b0, hb = 1'b0, we = 1'b0;
  logic [2:0] idx = '0, sel = '0;
  logic [NM-1:0] susp;

  int n_run = 0, n_fail = 0;
  logic [NM-1:0] exp_q[$];
  string tag_q[$];
  logic [2:0] shadow [NM];
  logic [NM-1:0] cur_exp = '0;

  always #2.5 clk = ~clk;

  dbg_suspend_combiner u0 (
    .clk(clk), .rst_n(rst_n), .halt_a_i(ha), .halt_b_i(hb),
    .cfg_we_i(we), .cfg_idx_i(idx), .cfg_sel_i(sel), .susp_o(susp));

  function automatic logic [NM-1:0] model(input logic a, input logic b);
    logic [NM-1:0] v;
    for (int i = 0; i < NM; i++) begin
      case (shadow[i])
        3'd1: v[i] = a;
        3'd2: v[i] = b;
        3'd3: v[i] = a & b;
        3'd4: v[i] = a | b;
        default: v[i] = 1'b0;
      endcase
    end
    return v & MASK;
  endfunction

  task automatic check(input string tag, input logic [NM-1:0] act,
                       input logic [NM-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push(input logic [NM-1:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Called at a negedge. Old value is expected for two samples (latency), then new.
  task automatic hold(input logic a, input logic b, input int n, input string tag);
    logic [NM-1:0] nv;
    ha = a; hb = b;
    nv = model(a, b);
    push(cur_exp, {tag, " latency"}); @(negedge clk);
    push(cur_exp, {tag, " latency"}); @(negedge clk);
    for (int k = 0; k < n; k++) begin
      push(nv, tag); @(negedge clk);
    end
    cur_exp = nv;
  endtask

  // Called at a negedge with halts settled.
  task automatic write(input logic [2:0] i, input logic [2:0] s, input string tag);
    we = 1'b1; idx = i; sel = s;
    push(cur_exp, {tag, " before"});
    if (i < 3'(NM)) shadow[i] = s;
    @(negedge clk);
    we = 1'b0;
    cur_exp = model(ha, hb);
    push(cur_exp, tag);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), susp, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < NM; i++) shadow[i] = 3'd0;
    repeat (3) @(negedge clk);
    check("R1 during reset", susp, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", susp, '0);
    @(negedge clk);
    // R1: fields start off, so a halt gives nothing before any write.
    hold(1'b1, 1'b1, 3, "R1 fields off");
    hold(1'b0, 1'b0, 3, "R1 fields off");
    write(3'd0, 3'd1, "R2 cfg");
    write(3'd1, 3'd2, "R3 cfg");
    write(3'd2, 3'd3, "R4 cfg");
    write(3'd3, 3'd4, "R5 cfg");
    write(3'd4, 3'd1, "R7 cfg");
    write(3'd5, 3'd6, "R6 cfg");
    write(3'd6, 3'd1, "R8 out of range");
    hold(1'b1, 1'b0, 4, "R2 R5 A only");
    hold(1'b0, 1'b1, 4, "R3 R5 B only");
    hold(1'b1, 1'b1, 4, "R4 both");
    hold(1'b0, 1'b0, 4, "R9 none");
    hold(1'b1, 1'b0, 4, "R5 A held");
    hold(1'b1, 1'b1, 3, "R5 step B");
    hold(1'b1, 1'b0, 3, "R5 step B");
    hold(1'b1, 1'b1, 3, "R5 step B");
    write(3'd5, 3'd7, "R6 code7");
    write(3'd2, 3'd5, "R6 code5");
    write(3'd0, 3'd0, "R6 code0");
    write(3'd5, 3'd4, "R8 live write");
    // Write lands while a falling halt is still in the synchronizer.
    ha = 1'b0; hb = 1'b0;
    we = 1'b1; idx = 3'd1; sel = 3'd1;
    push(cur_exp, "R8 overlap before");
    shadow[1] = 3'd1;
    @(negedge clk); we = 1'b0;
    push(model(1'b1, 1'b1), "R8 overlap new sel old halt");
    @(negedge clk);
    push(model(1'b0, 1'b0), "R8 overlap settled");
    @(negedge clk);
    cur_exp = model(1'b0, 1'b0);
    hold(1'b0, 1'b0, 3, "R10 steady");
    hold(1'b1, 1'b0, 3, "R2 final");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule